// File: doc/BRIEF.md
# Byte-mode ADC readout controller

This block sits on the host side of a 12-bit sampling converter whose result is fetched over an 8-bit bus. When the host raises `start` while the block is idle, the block drives a convert-start pulse. The converter holds its sample on the rising edge of that pulse. The block then watches the active-low busy line: first for the converter to signal that a conversion is running, then for the line to return high.

Once the conversion is over, the block fetches the result in two byte reads under chip-select and read strobes. The low byte comes first and the high byte second, and a byte-select line picks between them. The block joins the two bytes into a 12-bit word and reports it with a one-cycle `valid` pulse.

The high byte carries the four top result bits in its lower nibble, and its upper nibble must read as zero. A nonzero upper nibble sets a sticky format flag, and the result is still delivered. A busy line that stays low for too long ends the attempt with an error pulse, and the block returns to idle.

Top module: `adc_byte_reader`

## Requirements
- R1: During and right after reset, `conv_start`=0, `cs_n`=1, `rd_n`=1, `hben`=0, `valid`=0, `fmt_err`=0 and `tmo_err`=0.
- R2: A `start` sampled high while idle drives `conv_start` high for exactly CONV_W consecutive cycles, and does so once per accepted request.
- R3: After the conversion, exactly two reads follow. In the first, `hben`=0 selects the low byte. In the second, `hben`=1 selects the high byte. `hben` does not change while `rd_n` is low.
- R4: Each read consists of one setup cycle, with `cs_n`=0, `rd_n`=1 and `hben` already at its read value, followed by RD_W (at least 2) cycles with both `cs_n` and `rd_n` low. `rd_n` is never low while `cs_n` is high.
- R5: The bus is sampled on the last cycle of each read strobe. `result` = {high byte bits 3..0, low byte bits 7..0}. In the cycle after the last high-byte strobe cycle, `valid` is high for exactly one cycle.
- R6: Chip-select is first asserted only after `busy_n` has been seen low and then high again.
- R7: A `start` request is ignored while a conversion is pending or a readout is in progress: no extra `conv_start` pulse and no extra result.
- R8: If bits 7..4 of the high byte are nonzero, `fmt_err` goes high and stays high until reset, and the result is still output.
- R9: If `busy_n` stays low for TMO_CYC cycles after it was seen low, `tmo_err` pulses high for one cycle. The block then returns to idle without reading and accepts a new `start`. A busy span well below TMO_CYC completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| busy_n | input | 1 | Converter busy, active low |
| data_in | input | 8 | Converter data bus |
| conv_start | output | 1 | Convert-start pulse; its rising edge begins a conversion |
| cs_n | output | 1 | Chip-select, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | Byte select: 0 = low byte, 1 = high byte |
| result | output | 12 | Assembled conversion result |
| valid | output | 1 | One-cycle pulse marking a new `result` |
| fmt_err | output | 1 | Sticky flag: high byte had a nonzero upper nibble |
| tmo_err | output | 1 | One-cycle pulse on a busy timeout |

## Verification
The properties assume that the converter pulls `busy_n` low only after a convert-start edge, keeps it high once a conversion ends, and drives the bus only while both strobes are low. The bench's converter model follows these rules. It starts a busy window a fixed delay after each rising `conv_start` edge, holds `busy_n` high outside that window, and puts a byte on the bus, chosen by `hben`, only while `cs_n` and `rd_n` are both low. A stuck-low setting of the model exercises the timeout path, and the model drains its busy window before the next request.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_SETUP,
        ST_STROBE
    } rd_state_e;

    typedef struct packed {
        logic conv;
        logic cs_n;
        logic rd_n;
        logic hben;
    } bus_ctl_t;

    typedef struct packed {
        logic [11:0] word;
        logic        bad_fmt;
    } rd_word_t;

    function automatic bus_ctl_t decode_ctl(rd_state_e st, logic hi);
        bus_ctl_t c;
        c.conv = (st == ST_CONV);
        c.cs_n = !((st == ST_SETUP) || (st == ST_STROBE));
        c.rd_n = (st != ST_STROBE);
        c.hben = hi;
        return c;
    endfunction

    function automatic rd_word_t join_bytes(logic [7:0] hi_b, logic [7:0] lo_b);
        rd_word_t w;
        w.word    = {hi_b[3:0], lo_b};
        w.bad_fmt = |hi_b[7:4];
        return w;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_rd_count.sv
module adc_rd_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int CW      = 8,
    parameter int CONV_W  = 2,
    parameter int RD_W    = 3,
    parameter int TMO_CYC = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          busy_n,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output bus_ctl_t      ctl,
    output logic          cap_lo,
    output logic          cap_hi,
    output logic          tmo_pulse
);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_W - 1);
    localparam logic [CW-1:0] RD_LAST   = CW'(RD_W - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);

    rd_state_e st_q, st_d;
    logic      hi_q, hi_d;
    logic      tmo_d;

    always_comb begin
        st_d   = st_q;
        hi_d   = hi_q;
        cap_lo = 1'b0;
        cap_hi = 1'b0;
        tmo_d  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                hi_d = 1'b0;
                if (start) st_d = ST_CONV;
            end
            ST_CONV: begin
                if (cnt == CONV_LAST) st_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (!busy_n) begin
                    st_d = ST_WAIT_HI;
                end else if (cnt == TMO_LAST) begin
                    st_d  = ST_IDLE;
                    tmo_d = 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (busy_n) begin
                    st_d = ST_SETUP;
                    hi_d = 1'b0;
                end else if (cnt == TMO_LAST) begin
                    st_d  = ST_IDLE;
                    tmo_d = 1'b1;
                end
            end
            ST_SETUP: begin
                st_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (cnt == RD_LAST) begin
                    if (!hi_q) begin
                        cap_lo = 1'b1;
                        hi_d   = 1'b1;
                        st_d   = ST_SETUP;
                    end else begin
                        cap_hi = 1'b1;
                        hi_d   = 1'b0;
                        st_d   = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign cnt_clr = (st_d != st_q) || (st_q == ST_IDLE);
    assign ctl     = decode_ctl(st_q, hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            hi_q      <= 1'b0;
            tmo_pulse <= 1'b0;
        end else begin
            st_q      <= st_d;
            hi_q      <= hi_d;
            tmo_pulse <= tmo_d;
        end
    end
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble
    import adc_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  data_in,
    input  logic        cap_lo,
    input  logic        cap_hi,
    output logic [11:0] result,
    output logic        valid,
    output logic        fmt_err
);
    logic [7:0] lo_q;
    rd_word_t   joined;

    assign joined = join_bytes(data_in, lo_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            result  <= '0;
            valid   <= 1'b0;
            fmt_err <= 1'b0;
        end else begin
            valid <= cap_hi;
            if (cap_lo) lo_q <= data_in;
            if (cap_hi) begin
                result  <= joined.word;
                fmt_err <= fmt_err | joined.bad_fmt;
            end
        end
    end
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
    import adc_rd_pkg::*;
#(
    parameter int CONV_W  = 2,
    parameter int RD_W    = 3,
    parameter int TMO_CYC = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        busy_n,
    input  logic [7:0]  data_in,
    output logic        conv_start,
    output logic        cs_n,
    output logic        rd_n,
    output logic        hben,
    output logic [11:0] result,
    output logic        valid,
    output logic        fmt_err,
    output logic        tmo_err
);
    localparam int RD_EFF   = (RD_W < 2) ? 2 : RD_W;
    localparam int CONV_EFF = (CONV_W < 1) ? 1 : CONV_W;
    localparam int TMO_EFF  = (TMO_CYC < 2) ? 2 : TMO_CYC;
    localparam int CW       = $clog2(max3(CONV_EFF, RD_EFF, TMO_EFF) + 1);

    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cap_lo, cap_hi;
    bus_ctl_t      ctl;

    adc_rd_count #(.W(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    adc_rd_fsm #(
        .CW      (CW),
        .CONV_W  (CONV_EFF),
        .RD_W    (RD_EFF),
        .TMO_CYC (TMO_EFF)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy_n    (busy_n),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .ctl       (ctl),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .tmo_pulse (tmo_err)
    );

    adc_rd_assemble u_asm (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .result  (result),
        .valid   (valid),
        .fmt_err (fmt_err)
    );

    assign conv_start = ctl.conv;
    assign cs_n       = ctl.cs_n;
    assign rd_n       = ctl.rd_n;
    assign hben       = ctl.hben;
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk (
    input logic clk,
    input logic rst,
    input logic busy_n,
    input logic conv_start,
    input logic cs_n,
    input logic rd_n,
    input logic hben,
    input logic valid,
    input logic fmt_err,
    input logic tmo_err
);
    a_r4_rd_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !cs_n);

    a_r4_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> ($past(!cs_n) && $past(rd_n)));

    a_r3_hben_stable: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> $stable(hben));

    a_r2_conv_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_start) |-> (cs_n && rd_n));

    a_r6_read_after_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(busy_n));

    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r8_fmt_sticky: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> fmt_err);

    a_r9_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
        tmo_err |=> !tmo_err);
endmodule

bind adc_byte_reader adc_byte_reader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_n     (busy_n),
    .conv_start (conv_start),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hben       (hben),
    .valid      (valid),
    .fmt_err    (fmt_err),
    .tmo_err    (tmo_err)
);

// File: tb/adc_byte_reader_test.sv
module adc_byte_reader_test;
    localparam int CONV_W  = 2;
    localparam int RD_W    = 3;
    localparam int TMO_CYC = 40;
    localparam int DLY     = 2;
    localparam int LEN     = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy_n;
    logic [7:0]  data_in;
    logic        conv_start, cs_n, rd_n, hben, valid, fmt_err, tmo_err;
    logic [11:0] result;

    always #5 clk = ~clk;

    adc_byte_reader #(.CONV_W(CONV_W), .RD_W(RD_W), .TMO_CYC(TMO_CYC)) uut (
        .clk(clk), .rst(rst), .start(start), .busy_n(busy_n), .data_in(data_in),
        .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .result(result), .valid(valid), .fmt_err(fmt_err), .tmo_err(tmo_err)
    );

    // converter model
    logic [11:0] m_word = '0;
    logic [3:0]  m_pad  = '0;
    logic        m_stuck = 1'b0;
    logic        m_conv_prev;
    int          m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt       <= 0;
            m_conv_prev <= 1'b0;
        end else begin
            m_conv_prev <= conv_start;
            if (conv_start && !m_conv_prev) m_cnt <= DLY + LEN;
            else if (m_cnt != 0) m_cnt <= m_cnt - 1;
        end
    end

    assign busy_n  = !(m_stuck || (m_cnt != 0 && m_cnt <= LEN));
    assign data_in = (!cs_n && !rd_n) ? (hben ? {m_pad, m_word[11:8]} : m_word[7:0]) : 8'h00;

    // scoreboard bookkeeping
    int          n_run = 0, n_fail = 0;
    logic [11:0] exp_q[$];
    int          got = 0, conv_rises = 0, strobes = 0, tmo_seen = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    logic p_conv = 0, p_cs_n = 1, p_rd_n = 1, p_hben = 0, p_tmo = 0, p_busy_n = 1;
    int   conv_w_cnt = 0, rd_w_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected valid", int'(result), 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(result == e, "R5 result", int'(result), int'(e));
                end
                got++;
            end
            if (conv_start) conv_w_cnt++;
            if (conv_start && !p_conv) conv_rises++;
            if (!conv_start && p_conv) begin
                check(conv_w_cnt == CONV_W, "R2 conv_start width", conv_w_cnt, CONV_W);
                conv_w_cnt = 0;
            end
            if (!rd_n) rd_w_cnt++;
            if (!rd_n && p_rd_n) begin
                check(hben == strobes[0], "R3 byte order", int'(hben), strobes[0]);
                check(!p_cs_n && p_hben == hben, "R4 setup cycle", int'(p_cs_n), 0);
                strobes++;
            end
            if (rd_n && !p_rd_n) begin
                check(rd_w_cnt == RD_W, "R4 strobe width", rd_w_cnt, RD_W);
                rd_w_cnt = 0;
            end
            if (!cs_n && p_cs_n)
                check(p_busy_n == 1'b1, "R6 read after busy", int'(p_busy_n), 1);
            if (tmo_err) tmo_seen++;
            if (p_tmo) check(!tmo_err, "R9 tmo one cycle", int'(tmo_err), 0);
        end
        p_conv   = conv_start;
        p_cs_n   = cs_n;
        p_rd_n   = rd_n;
        p_hben   = hben;
        p_tmo    = tmo_err;
        p_busy_n = busy_n;
    end

    // driver
    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_conv(input logic [11:0] v, input logic [3:0] pad, input bit extra);
        int target;
        target = got + 1;
        @(negedge clk);
        m_word = v;
        m_pad  = pad;
        exp_q.push_back(v);
        pulse_start();
        if (extra) begin
            repeat (6) @(negedge clk);
            pulse_start();                    // R7: during conversion
            while (cs_n) @(negedge clk);
            start = 1'b1;                     // R7: during readout
            @(negedge clk);
            start = 1'b0;
        end
        while (got < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", got, exp_q.size());
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int s0, r0, g0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check({conv_start, cs_n, rd_n, hben, valid, fmt_err, tmo_err} == 7'b0110000,
              "R1 reset outputs", {conv_start, cs_n, rd_n, hben, valid, fmt_err, tmo_err}, 7'b0110000);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && rd_n && !conv_start, "R1 idle after reset", int'(cs_n), 1);

        run_conv(12'h000, 4'h0, 1'b0);
        run_conv(12'hFFF, 4'h0, 1'b0);
        run_conv(12'hA5C, 4'h0, 1'b0);
        run_conv(12'h801, 4'h0, 1'b0);
        check(conv_rises == 4, "R2 one pulse per request", conv_rises, 4);
        check(strobes == 8, "R3 two reads per result", strobes, 8);
        check(!fmt_err, "R8 no format error on clean data", int'(fmt_err), 0);

        run_conv(12'h3C7, 4'h0, 1'b1);
        check(conv_rises == 5, "R7 start ignored while busy", conv_rises, 5);
        check(got == 5, "R7 no extra result", got, 5);

        run_conv(12'h5A6, 4'h9, 1'b0);
        check(fmt_err, "R8 format error set", int'(fmt_err), 1);
        run_conv(12'h123, 4'h0, 1'b0);
        check(fmt_err, "R8 format error sticky", int'(fmt_err), 1);

        // R9 timeout
        s0 = strobes; r0 = tmo_seen; g0 = got;
        m_stuck = 1'b1;
        pulse_start();
        while (tmo_seen == r0) @(negedge clk);
        check(tmo_seen == r0 + 1, "R9 timeout pulse", tmo_seen, r0 + 1);
        repeat (5) @(negedge clk);
        check(strobes == s0 && got == g0, "R9 no read on timeout", strobes, s0);
        check(cs_n && rd_n && !conv_start, "R9 back to idle", int'(cs_n), 1);
        m_stuck = 1'b0;
        repeat (DLY + LEN + 4) @(negedge clk);
        run_conv(12'h7E2, 4'h0, 1'b0);
        check(got == g0 + 1, "R9 recovers after timeout", got, g0 + 1);
        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule